// File: doc/BRIEF.md
# Test Pattern Checker (PRBS-11 and static byte)

This block checks a test pattern that arrives in one selected timeslot of a time-division serial link. Upstream framing logic hands it one byte per occurrence of the selected timeslot, together with a pulse that marks every 125 µs frame. The block works in one of two modes. In static mode every byte is compared with a programmed reference byte. In pseudo-random mode the block locks onto a PRBS-11 stream (x^11 + x^9 + 1) without any alignment hint and then checks every bit.

Software controls the block through a small register port. It programs the link and timeslot that the demultiplexer should select, the reference byte and the mode. It reads back the captured byte, the sync and activity status, and two saturating counters: one for frames while in sync and one for errors.

Byte input uses valid/ready. The block never applies back-pressure: `in_ready` is held high, and a byte transfers on every cycle in which `in_valid` is high. While checking is inactive, accepted bytes are dropped. `frame_tick`, the register port and the status pins are plain signals.

Top module: `tpat_checker`

## Requirements
- R1: Register 1 holds the timeslot in bits [8:0] and the link in bits [14:9]. A write whose link field is above 59 leaves the register unchanged. `sel_link` and `sel_slot` mirror the stored fields.
- R2: Register 0 has enable in bit 0 and mode in bit 1 (1 = PRBS, 0 = static). A write that changes enable from 0 to 1 sets the active status, clears both counters, drops sync and latches the mode for the run.
- R3: Register 4 reads sync in bit 0 and active in bit 1. After enable is cleared, active stays 1 and bytes are still checked until the next `frame_tick`. Active is 0 after that tick.
- R4: In PRBS mode the bits of each byte are taken MSB first. The first 11 bits load the shift register. Sync is declared after 16 consecutive correct predictions, so on a clean stream sync appears with the 27th bit, in the 4th byte. A wrong prediction restarts loading with that bit.
- R5: In PRBS sync, each received bit that differs from the locally generated sequence adds one to the error counter (register 6). The local generator does not take in received bits.
- R6: In PRBS sync, the 8th bit error within one frame drops sync and restarts acquisition. `frame_tick` resets the per-frame tally.
- R7: In static mode register 3 captures the most recent byte. Sync is declared at the tick ending the second consecutive frame whose bytes all matched the reference (register 2). Frames with no byte leave the state unchanged. A frame with any mismatch drops sync at its tick.
- R8: In static sync, each mismatching byte adds one to the error counter.
- R9: The frame counter (register 5) increments on each `frame_tick` at which the block is active and in sync, as seen before that tick.
- R10: Both counters saturate at all ones instead of wrapping.
- R11: `in_ready` is always 1. Bytes that arrive while inactive change neither the capture register nor the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| in_valid | input | 1 | Received timeslot byte is valid |
| in_ready | output | 1 | Always 1, no back-pressure |
| in_data | input | 8 | Received timeslot byte |
| frame_tick | input | 1 | One-cycle pulse per 125 µs frame |
| sel_link | output | 6 | Selected link for the demultiplexer |
| sel_slot | output | 9 | Selected timeslot for the demultiplexer |
| sync_o | output | 1 | Pattern in sync |
| active_o | output | 1 | Checker running |

## Verification
A corrupted PRBS shift register or a wrong tap shows up as a stream of errors. Within one frame the 8-error limit then drops the sync bit, and the sync bit on a clean stream rises in the wrong byte. A wrong static run counter moves the sync bit to the wrong frame tick, and the frame counter is off by one within two frames. A stop-logic fault shows up as the active bit falling before a frame tick, or bytes still counted after it.

// File: rtl/tpat_pkg.sv
package tpat_pkg;
  typedef enum logic [2:0] {
    A_CTRL = 3'd0,
    A_SEL  = 3'd1,
    A_REF  = 3'd2,
    A_CAP  = 3'd3,
    A_STAT = 3'd4,
    A_FRM  = 3'd5,
    A_ERR  = 3'd6
  } reg_addr_e;

  localparam int LFSR_LEN = 11;
  localparam int TAP_NEAR = 9;
  localparam int MAX_LINK = 59;
endpackage

// File: rtl/tpat_regs.sv
module tpat_regs
  import tpat_pkg::*;
#(
  parameter int LINK_W = 6,
  parameter int SLOT_W = 9,
  parameter int LINK_MAX = MAX_LINK
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              frame_tick,
  output logic              start,
  output logic              active,
  output logic              mode_prbs,
  output logic [LINK_W-1:0] sel_link,
  output logic [SLOT_W-1:0] sel_slot,
  output logic [7:0]        ref_byte
);
  logic en_q;
  logic wr_ctrl, wr_sel;
  logic [LINK_W-1:0] new_link;

  assign wr_ctrl  = wr_en && (wr_addr == A_CTRL);
  assign wr_sel   = wr_en && (wr_addr == A_SEL);
  assign new_link = wr_data[SLOT_W +: LINK_W];
  assign start    = wr_ctrl && wr_data[0] && !en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      active    <= 1'b0;
      mode_prbs <= 1'b0;
      sel_link  <= '0;
      sel_slot  <= '0;
      ref_byte  <= '0;
    end else begin
      if (wr_ctrl) en_q <= wr_data[0];
      if (start) begin
        active    <= 1'b1;
        mode_prbs <= wr_data[1];
      end else if (!en_q && frame_tick) begin
        active <= 1'b0;
      end
      if (wr_sel && new_link <= LINK_W'(LINK_MAX)) begin
        sel_link <= new_link;
        sel_slot <= wr_data[SLOT_W-1:0];
      end
      if (wr_en && wr_addr == A_REF) ref_byte <= wr_data[7:0];
    end
  end

  assert_link_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sel_link <= LINK_W'(LINK_MAX));
  assert_start_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> active);
  assert_stop_on_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !frame_tick) |=> active);
endmodule

// File: rtl/tpat_prbs.sv
module tpat_prbs
  import tpat_pkg::*;
#(
  parameter int LEN      = LFSR_LEN,
  parameter int TAP      = TAP_NEAR,
  parameter int SYNC_RUN = 16,
  parameter int LOSS_LIM = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       byte_vld,
  input  logic [7:0] byte_in,
  input  logic       frame_tick,
  output logic       locked,
  output logic [3:0] err_n
);
  localparam int CW = $clog2(LEN + 1);
  localparam int GW = $clog2(SYNC_RUN + 1);
  localparam int FW = $clog2(LOSS_LIM + 1);

  logic [LEN-1:0] sr_q, sr_n;
  logic           lk_q, lk_n;
  logic [CW-1:0]  ld_q, ld_n;
  logic [GW-1:0]  gd_q, gd_n;
  logic [FW-1:0]  fe_q, fe_n;
  logic [3:0]     errs;
  logic           bit_v, pred_v;

  always_comb begin
    sr_n   = sr_q;
    lk_n   = lk_q;
    ld_n   = ld_q;
    gd_n   = gd_q;
    fe_n   = fe_q;
    errs   = '0;
    bit_v  = 1'b0;
    pred_v = 1'b0;
    if (byte_vld) begin
      for (int i = 7; i >= 0; i--) begin
        bit_v  = byte_in[i];
        pred_v = sr_n[LEN-1] ^ sr_n[TAP-1];
        if (!lk_n) begin
          sr_n = {sr_n[LEN-2:0], bit_v};
          if (ld_n < CW'(LEN)) begin
            ld_n = ld_n + 1'b1;
          end else if (bit_v == pred_v) begin
            if (gd_n == GW'(SYNC_RUN - 1)) begin
              lk_n = 1'b1;
              gd_n = '0;
              fe_n = '0;
            end else begin
              gd_n = gd_n + 1'b1;
            end
          end else begin
            ld_n = CW'(1);
            gd_n = '0;
          end
        end else begin
          sr_n = {sr_n[LEN-2:0], pred_v};
          if (bit_v != pred_v) begin
            errs = errs + 4'd1;
            if (fe_n == FW'(LOSS_LIM - 1)) begin
              lk_n = 1'b0;
              ld_n = '0;
              gd_n = '0;
              fe_n = '0;
            end else begin
              fe_n = fe_n + 1'b1;
            end
          end
        end
      end
    end
    if (frame_tick) fe_n = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      sr_q <= '0;
      lk_q <= 1'b0;
      ld_q <= '0;
      gd_q <= '0;
      fe_q <= '0;
    end else begin
      sr_q <= sr_n;
      lk_q <= lk_n;
      ld_q <= ld_n;
      gd_q <= gd_n;
      fe_q <= fe_n;
    end
  end

  assign locked = lk_q;
  assign err_n  = errs;

  assert_frame_tally_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fe_q < FW'(LOSS_LIM));
  assert_lock_needs_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!lk_q && !byte_vld) |=> !lk_q);
  assert_load_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ld_q <= CW'(LEN));
endmodule

// File: rtl/tpat_static.sv
module tpat_static #(
  parameter int NEED = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       byte_vld,
  input  logic [7:0] byte_in,
  input  logic [7:0] ref_byte,
  input  logic       frame_tick,
  output logic [7:0] cap,
  output logic       in_sync,
  output logic       err
);
  localparam int RW = $clog2(NEED + 1);

  logic          bad_q, got_q, sync_q;
  logic [RW-1:0] run_q;
  logic          mism, bad_now, got_now, good_frame;
  logic [RW-1:0] run_next;

  assign mism       = byte_vld && (byte_in != ref_byte);
  assign bad_now    = bad_q | mism;
  assign got_now    = got_q | byte_vld;
  assign good_frame = got_now && !bad_now;
  assign run_next   = (run_q == RW'(NEED)) ? run_q : run_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) cap <= '0;
    else if (byte_vld) cap <= byte_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      bad_q  <= 1'b0;
      got_q  <= 1'b0;
      sync_q <= 1'b0;
      run_q  <= '0;
    end else if (frame_tick) begin
      bad_q <= 1'b0;
      got_q <= 1'b0;
      if (good_frame) begin
        run_q  <= run_next;
        sync_q <= (run_next == RW'(NEED));
      end else if (bad_now) begin
        run_q  <= '0;
        sync_q <= 1'b0;
      end
    end else begin
      bad_q <= bad_now;
      got_q <= got_now;
    end
  end

  assign in_sync = sync_q;
  assign err     = mism && sync_q;

  assert_sync_rise_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_q && !frame_tick) |=> !sync_q);
  assert_sync_hold_in_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_q && !frame_tick && !clr) |=> sync_q);
endmodule

// File: rtl/tpat_satcnt.sv
module tpat_satcnt #(
  parameter int CNT_W = 32,
  parameter int INC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [INC_W-1:0] inc,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W:0] sum;

  assign sum = {1'b0, cnt} + (CNT_W+1)'(inc);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (sum[CNT_W]) cnt <= '1;
    else cnt <= sum[CNT_W-1:0];
  end

  assert_no_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> cnt >= $past(cnt));
  assert_sat_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '1 && !clr) |=> cnt == '1);
endmodule

// File: rtl/tpat_checker.sv
module tpat_checker
  import tpat_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int SYNC_RUN = 16,
  parameter int LOSS_LIM = 8,
  parameter int ST_NEED  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [2:0]  rd_addr,
  output logic [31:0] rd_data,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        frame_tick,
  output logic [5:0]  sel_link,
  output logic [8:0]  sel_slot,
  output logic        sync_o,
  output logic        active_o
);
  logic       start, active, mode_prbs;
  logic [7:0] ref_byte, cap;
  logic       acc, eng_clr, p_lock, s_sync, s_err, sync;
  logic [3:0] p_err, err_inc;
  logic [CNT_W-1:0] frm_cnt, err_cnt;

  tpat_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .frame_tick(frame_tick), .start(start), .active(active), .mode_prbs(mode_prbs),
    .sel_link(sel_link), .sel_slot(sel_slot), .ref_byte(ref_byte)
  );

  assign in_ready = 1'b1;
  assign acc      = in_valid && in_ready && active;
  assign eng_clr  = start || !active;

  tpat_prbs #(.SYNC_RUN(SYNC_RUN), .LOSS_LIM(LOSS_LIM)) u_prbs (
    .clk(clk), .rst_n(rst_n), .clr(eng_clr), .byte_vld(acc && mode_prbs),
    .byte_in(in_data), .frame_tick(frame_tick), .locked(p_lock), .err_n(p_err)
  );

  tpat_static #(.NEED(ST_NEED)) u_static (
    .clk(clk), .rst_n(rst_n), .clr(eng_clr), .byte_vld(acc && !mode_prbs),
    .byte_in(in_data), .ref_byte(ref_byte), .frame_tick(frame_tick),
    .cap(cap), .in_sync(s_sync), .err(s_err)
  );

  assign sync    = mode_prbs ? p_lock : s_sync;
  assign err_inc = active ? (mode_prbs ? p_err : {3'b000, s_err}) : 4'd0;

  tpat_satcnt #(.CNT_W(CNT_W), .INC_W(1)) u_frm (
    .clk(clk), .rst_n(rst_n), .clr(start),
    .inc(frame_tick && active && sync), .cnt(frm_cnt)
  );

  tpat_satcnt #(.CNT_W(CNT_W), .INC_W(4)) u_err (
    .clk(clk), .rst_n(rst_n), .clr(start), .inc(err_inc), .cnt(err_cnt)
  );

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = {31'd0, active};
      A_SEL:   rd_data = {17'd0, sel_link, sel_slot};
      A_REF:   rd_data = {24'd0, ref_byte};
      A_CAP:   rd_data = {24'd0, cap};
      A_STAT:  rd_data = {30'd0, active, sync};
      A_FRM:   rd_data = 32'(frm_cnt);
      A_ERR:   rd_data = 32'(err_cnt);
      default: rd_data = '0;
    endcase
  end

  assign sync_o   = sync;
  assign active_o = active;

  assert_idle_no_sync_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!sync_o || active_o));
  assert_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready);
endmodule

// File: tb/tpat_checker_tb_top.sv
module tpat_checker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        frame_tick = 1'b0;
  logic [5:0]  sel_link;
  logic [8:0]  sel_slot;
  logic        sync_o, active_o;

  always #5 clk = ~clk;

  tpat_checker #(.CNT_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .frame_tick(frame_tick), .sel_link(sel_link), .sel_slot(sel_slot),
    .sync_o(sync_o), .active_o(active_o)
  );

  typedef struct {
    logic [2:0]  addr;
    logic [31:0] val;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 0;
  logic [10:0] gen = 11'h5A3;

  // scoreboard monitor: pops expected register values and compares
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        exp_t it;
        it = exp_q.pop_front();
        rd_addr = it.addr;
        #1;
        n_run++;
        if (rd_data !== it.val) begin
          n_fail++;
          $display("FAIL %s: reg %0d actual %0h expected %0h", it.tag, it.addr, rd_data, it.val);
        end
      end
    end
  end

  task automatic chk(input logic [2:0] a, input logic [31:0] v, input string tag);
    exp_t it;
    it.addr = a; it.val = v; it.tag = tag;
    exp_q.push_back(it);
    while (exp_q.size() != 0) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk); in_valid = 1'b1; in_data = b;
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); frame_tick = 1'b1;
    @(negedge clk); frame_tick = 1'b0;
  endtask

  // next PRBS-11 byte (x^11+x^9+1), MSB first, with chosen bits inverted
  task automatic prbs_byte(input logic [7:0] flip);
    logic [7:0] b;
    for (int i = 7; i >= 0; i--) begin
      logic nb;
      nb = gen[10] ^ gen[8];
      gen = {gen[9:0], nb};
      b[i] = nb ^ flip[i];
    end
    put(b);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(3'd4, 32'd0, "R2 reset status");
    chk(3'd5, 32'd0, "R9 reset frames");
    chk(3'd6, 32'd0, "R10 reset errors");

    // R1: link/timeslot register
    wr(3'd1, (32'd59 << 9) | 32'd511);
    chk(3'd1, (32'd59 << 9) | 32'd511, "R1 sel write");
    wr(3'd1, (32'd60 << 9) | 32'd3);
    chk(3'd1, (32'd59 << 9) | 32'd511, "R1 link 60 ignored");
    n_run++;
    if (sel_link !== 6'd59 || sel_slot !== 9'd511) begin
      n_fail++;
      $display("FAIL R1 sel ports actual %0d/%0d expected 59/511", sel_link, sel_slot);
    end

    // R11: bytes dropped while inactive, no back-pressure
    put(8'h33);
    chk(3'd3, 32'd0, "R11 capture untouched while inactive");
    n_run++;
    if (in_ready !== 1'b1) begin
      n_fail++;
      $display("FAIL R11 in_ready actual %0b expected 1", in_ready);
    end

    // PRBS run
    wr(3'd0, 32'd3);
    chk(3'd4, 32'd2, "R2 active after enable");
    repeat (3) prbs_byte(8'h00);
    chk(3'd4, 32'd2, "R4 no sync after 24 bits");
    prbs_byte(8'h00);
    chk(3'd4, 32'd3, "R4 sync in 4th byte");
    chk(3'd6, 32'd0, "R5 no errors on clean stream");
    repeat (3) tick();
    chk(3'd5, 32'd3, "R9 frames counted in sync");
    prbs_byte(8'h10);
    chk(3'd6, 32'd1, "R5 single bit error");
    tick();
    prbs_byte(8'hA4);
    chk(3'd6, 32'd4, "R5 three bit errors");
    chk(3'd4, 32'd3, "R6 sync kept at 3 errors");
    prbs_byte(8'h1F);
    chk(3'd6, 32'd9, "R6 errors up to loss");
    chk(3'd4, 32'd2, "R6 sync lost at 8th error");
    tick();
    chk(3'd5, 32'd4, "R9 no frame count out of sync");
    repeat (3) prbs_byte(8'h00);
    chk(3'd4, 32'd2, "R4 reacquire not before 27 bits");
    prbs_byte(8'h00);
    chk(3'd4, 32'd3, "R4 reacquired");

    // R3: graceful stop
    wr(3'd0, 32'd2);
    chk(3'd4, 32'd3, "R3 still active before frame end");
    prbs_byte(8'h01);
    chk(3'd6, 32'd10, "R3 checking continues until frame end");
    tick();
    chk(3'd4, 32'd0, "R3 stopped after frame tick");
    chk(3'd5, 32'd5, "R9 last frame counted");

    // static run
    wr(3'd2, 32'hA5);
    wr(3'd0, 32'd1);
    chk(3'd5, 32'd0, "R2 frames cleared on enable");
    chk(3'd6, 32'd0, "R2 errors cleared on enable");
    put(8'hA5); tick();
    chk(3'd4, 32'd2, "R7 one good frame not enough");
    put(8'hA5); put(8'hA5); tick();
    chk(3'd4, 32'd3, "R7 sync after two good frames");
    chk(3'd5, 32'd0, "R9 sync tick not counted");
    tick();
    chk(3'd4, 32'd3, "R7 empty frame keeps sync");
    chk(3'd5, 32'd1, "R9 frame counted");
    put(8'h5A);
    chk(3'd6, 32'd1, "R8 mismatch byte counted");
    chk(3'd3, 32'h5A, "R7 capture last byte");
    tick();
    chk(3'd4, 32'd2, "R7 bad frame drops sync");
    chk(3'd5, 32'd2, "R9 frame counted before drop");
    put(8'hA5); tick(); put(8'hA5); tick();
    chk(3'd4, 32'd3, "R7 resync");
    for (int k = 0; k < 20; k++) put(8'h00);
    chk(3'd6, 32'd15, "R10 error counter saturates");
    chk(3'd3, 32'h00, "R7 capture follows bytes");

    wr(3'd0, 32'd0);
    tick();
    put(8'h77);
    chk(3'd3, 32'h00, "R11 capture kept after stop");
    chk(3'd6, 32'd15, "R11 errors kept after stop");

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule